// File: doc/BRIEF.md
# Configuration Register Commit Controller

This block keeps a small bank of shadow configuration registers and decides when their contents are copied into nonvolatile storage. A bus slave outside this block decodes commands and hands in register-write strobes carrying a register index and data, together with a one-cycle commit command strobe. The block stores the writes and applies its commit policy. It then sends the registers one by one to a storage port. That port uses a request pulse and a busy handshake, and the block waits whenever the port reports busy.

The highest-indexed register is the bus-configuration register. It holds a three-bit device address, a write-control bit and reserved bits that always read as zero. The write-control bit sets the policy. When it is 0, every register write causes a full commit. When it is 1, writes change only the shadow copies, and a full commit happens only on the explicit command. A write to the bus-configuration register always commits that one register at once, whichever policy is active. The current device address is exported so that the bus slave can match incoming addresses.

A full commit sends one request per register, in ascending index order. Commit events that arrive while the storage port is in use are merged, so at most one full commit and one single-register commit wait at any time.

Top module: `ncc_cfg_commit`

## Requirements
- R1: After reset every shadow register reads zero, `dev_addr` is 0, the write-control bit is 0 and `nv_req` stays low until a commit event occurs.
- R2: The bus-configuration register is index NUM_REGS-1. Bits [2:0] hold the device address, bit 3 holds the write-control bit, and every bit above 3 reads as zero whatever was written to it.
- R3: While the write-control bit is 0, a write to any register other than the bus-configuration register starts a full commit.
- R4: While the write-control bit is 1, a write to any register other than the bus-configuration register updates that register's readback value and produces no storage request.
- R5: A commit command starts a full commit, whatever the write-control bit holds. A full commit issues exactly one request per register, with indices 0, 1, ..., NUM_REGS-1 in that order.
- R6: A write to the bus-configuration register produces exactly one storage request, for index NUM_REGS-1 only, whatever the write-control bit holds.
- R7: `nv_req` is asserted only in a cycle where `nv_busy` is low. It is never high in two consecutive cycles. A request that is due while `nv_busy` is high waits until busy clears.
- R8: Commit events that arrive while a commit is in progress merge. Any number of full-commit events during one full commit yield exactly one further full commit.
- R9: `dev_addr` equals bits [2:0] of the last value written to the bus-configuration register, from the cycle after that write.
- R10: `nv_data` carries the current shadow value of register `nv_id` in the cycle of the request. Once all commits have completed after a full commit, the stored image equals the shadow registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_id | input | ID_W | Index of the register to write |
| wr_data | input | DATA_W | Data to write |
| commit_cmd | input | 1 | Explicit full-commit command strobe |
| rd_id | input | ID_W | Index of the register to read back |
| rd_data | output | DATA_W | Shadow value of register `rd_id` (combinational) |
| dev_addr | output | 3 | Current device address |
| nv_req | output | 1 | Storage request pulse |
| nv_id | output | ID_W | Register index of the request |
| nv_data | output | DATA_W | Register data of the request |
| nv_busy | input | 1 | Storage port busy |

## Verification
A wrong pending flag or a wrong sequencer state shows at the storage port within a few cycles of the event that caused it. The symptoms are a request that should not appear, a request that is missing, or a request that appears twice. A sequencer index that drifts shows as requests out of ascending order, or as a full commit that does not cover every register. A shadow-register fault shows as `nv_data` that differs from the bench's expected value at the request cycle, or as a stored image that differs after the final commit. A fault in the bus-configuration register shows on `dev_addr` and on the readback port one cycle after the write.

// File: rtl/ncc_pkg.sv
package ncc_pkg;
    // field layout of the bus-configuration register
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned WC_BIT     = 3;
    localparam int unsigned CFG_USED_W = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ncc_shadow_regs.sv
module ncc_shadow_regs
    import ncc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ID_W-1:0]                  wr_id,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    output logic                             wc,
    output logic [ADDR_W-1:0]                dev_addr
);
    localparam int BUS_IDX = NUM_REGS - 1;
    localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((1 << CFG_USED_W) - 1);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } shadow_t;

    shadow_t s_d, s_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] keep_mask;

    // per-register mask: reserved bits exist only in the bus-configuration register
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
        if (g == BUS_IDX) begin : g_cfg
            assign keep_mask[g] = CFG_MASK;
        end else begin : g_plain
            assign keep_mask[g] = '1;
        end
    end

    always_comb begin
        s_d = s_q;
        for (int g = 0; g < NUM_REGS; g++) begin
            if (wr_en && (wr_id == ID_W'(g))) begin
                s_d.regs[g] = wr_data & keep_mask[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign regs     = s_q.regs;
    assign wc       = s_q.regs[BUS_IDX][WC_BIT];
    assign dev_addr = s_q.regs[BUS_IDX][ADDR_W-1:0];
endmodule

// File: rtl/ncc_commit_policy.sv
module ncc_commit_policy #(
    parameter int NUM_REGS = 4,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic            commit_cmd,
    input  logic            wc,
    input  logic            take_full,
    input  logic            take_one,
    output logic            pend_full,
    output logic            pend_one
);
    localparam int BUS_IDX = NUM_REGS - 1;

    typedef struct packed {
        logic full;
        logic one;
    } pend_t;

    pend_t p_d, p_q;
    logic  wr_ok, wr_cfg, new_full, new_one;

    always_comb begin
        wr_ok    = wr_en && (int'(wr_id) < NUM_REGS);
        wr_cfg   = wr_ok && (wr_id == ID_W'(BUS_IDX));
        // deferred mode only suppresses commits caused by ordinary writes
        new_full = commit_cmd || (wr_ok && !wr_cfg && !wc);
        new_one  = wr_cfg;

        p_d.full = (p_q.full && !take_full) || new_full;
        // a full commit also covers the bus-configuration register
        p_d.one  = (p_q.one && !take_one && !take_full) || new_one;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pend_full = p_q.full;
    assign pend_one  = p_q.one;
endmodule

// File: rtl/ncc_commit_seq.sv
module ncc_commit_seq
    import ncc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_full,
    input  logic            pend_one,
    input  logic            nv_busy,
    output logic            take_full,
    output logic            take_one,
    output logic            nv_req,
    output logic [ID_W-1:0] nv_id
);
    localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_REGS - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [ID_W-1:0] idx;
        logic            full;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        take_full = 1'b0;
        take_one  = 1'b0;
        nv_req    = 1'b0;
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (pend_full) begin
                    take_full = 1'b1;
                    s_d.state = SEQ_ISSUE;
                    s_d.idx   = '0;
                    s_d.full  = 1'b1;
                end else if (pend_one) begin
                    take_one  = 1'b1;
                    s_d.state = SEQ_ISSUE;
                    s_d.idx   = LAST_ID;
                    s_d.full  = 1'b0;
                end
            end
            SEQ_ISSUE: begin
                if (!nv_busy) begin
                    nv_req    = 1'b1;
                    s_d.state = SEQ_GAP;
                end
            end
            SEQ_GAP: begin
                // one quiet cycle lets the storage raise busy
                if (s_q.full && (s_q.idx != LAST_ID)) begin
                    s_d.idx   = s_q.idx + ID_W'(1);
                    s_d.state = SEQ_ISSUE;
                end else begin
                    s_d.state = SEQ_IDLE;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SEQ_IDLE, idx: '0, full: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign nv_id = s_q.idx;
endmodule

// File: rtl/ncc_cfg_commit.sv
module ncc_cfg_commit
    import ncc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_cmd,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        dev_addr,
    output logic              nv_req,
    output logic [ID_W-1:0]   nv_id,
    output logic [DATA_W-1:0] nv_data,
    input  logic              nv_busy
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic wc;
    logic pend_full, pend_one, take_full, take_one;

    ncc_shadow_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .wr_data  (wr_data),
        .regs     (regs),
        .wc       (wc),
        .dev_addr (dev_addr)
    );

    ncc_commit_policy #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_id      (wr_id),
        .commit_cmd (commit_cmd),
        .wc         (wc),
        .take_full  (take_full),
        .take_one   (take_one),
        .pend_full  (pend_full),
        .pend_one   (pend_one)
    );

    ncc_commit_seq #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_full (pend_full),
        .pend_one  (pend_one),
        .nv_busy   (nv_busy),
        .take_full (take_full),
        .take_one  (take_one),
        .nv_req    (nv_req),
        .nv_id     (nv_id)
    );

    always_comb begin
        rd_data = '0;
        if (int'(rd_id) < NUM_REGS) begin
            rd_data = regs[rd_id];
        end
    end

    assign nv_data = regs[nv_id];
endmodule

// File: rtl/ncc_cfg_commit_chk.sv
module ncc_cfg_commit_chk #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ID_W-1:0]   wr_id,
    input logic [DATA_W-1:0] wr_data,
    input logic [ID_W-1:0]   rd_id,
    input logic [DATA_W-1:0] rd_data,
    input logic [2:0]        dev_addr,
    input logic              nv_req,
    input logic [ID_W-1:0]   nv_id,
    input logic              nv_busy
);
    localparam logic [ID_W-1:0] CFG_ID = ID_W'(NUM_REGS - 1);

    a_r7_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> !nv_busy);

    a_r7_req_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id == CFG_ID) |-> (rd_data[DATA_W-1:4] == '0));

    a_r9_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == CFG_ID) |=> (dev_addr == $past(wr_data[2:0])));

    a_r5_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> (int'(nv_id) < NUM_REGS));
endmodule

bind ncc_cfg_commit ncc_cfg_commit_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_id    (wr_id),
    .wr_data  (wr_data),
    .rd_id    (rd_id),
    .rd_data  (rd_data),
    .dev_addr (dev_addr),
    .nv_req   (nv_req),
    .nv_id    (nv_id),
    .nv_busy  (nv_busy)
);

// File: tb/ncc_cfg_commit_tb_top.sv
module ncc_cfg_commit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_REGS   = 4;
    localparam int DATA_W     = 16;
    localparam int ID_W       = 2;
    localparam int BUS        = NUM_REGS - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              commit_cmd = 1'b0;
    logic [ID_W-1:0]   rd_id = '0;
    logic [DATA_W-1:0] rd_data;
    logic [2:0]        dev_addr;
    logic              nv_req;
    logic [ID_W-1:0]   nv_id;
    logic [DATA_W-1:0] nv_data;
    logic              nv_busy;

    int total = 0;
    int bad   = 0;
    int busy_max = 0;
    int busy_fix = 0;
    int busy_cnt = 0;
    int log_n = 0;
    logic [ID_W-1:0]   log_id [256];
    logic [DATA_W-1:0] exp_reg [NUM_REGS];
    logic [DATA_W-1:0] image   [NUM_REGS];

    ncc_cfg_commit #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data),
        .commit_cmd(commit_cmd), .rd_id(rd_id), .rd_data(rd_data), .dev_addr(dev_addr),
        .nv_req(nv_req), .nv_id(nv_id), .nv_data(nv_data), .nv_busy(nv_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] stored(input int id, input logic [DATA_W-1:0] d);
        return (id == BUS) ? (d & 16'h000F) : d;
    endfunction

    // storage model: busy for a chosen number of cycles after each request
    assign nv_busy = (busy_cnt != 0);
    always @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (nv_req) busy_cnt <= (busy_fix != 0) ? busy_fix : $urandom_range(busy_max, 0);
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    // request monitor, R7 and R10 per request
    always @(negedge clk) begin
        if (rst_n && nv_req) begin
            chk(!nv_busy, "R7 request while busy", 32'(nv_busy), 0);
            chk(nv_data == exp_reg[nv_id], "R10 request data", 32'(nv_data), 32'(exp_reg[nv_id]));
            image[nv_id] = nv_data;
            if (log_n < 256) log_id[log_n] = nv_id;
            log_n++;
        end
    end

    task automatic do_write(input int id, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_id = ID_W'(id); wr_data = d;
        @(posedge clk);
        exp_reg[id] = stored(id, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_cmd();
        commit_cmd = 1'b1;
        @(negedge clk);
        commit_cmd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_full(input string req);
        chk(log_n == NUM_REGS, req, 32'(log_n), NUM_REGS);
        for (int i = 0; i < NUM_REGS; i++)
            if (i < log_n) chk(log_id[i] == ID_W'(i), req, 32'(log_id[i]), 32'(i));
    endtask

    task automatic expect_single(input string req);
        chk(log_n == 1, req, 32'(log_n), 1);
        if (log_n > 0) chk(log_id[0] == ID_W'(BUS), req, 32'(log_id[0]), BUS);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        for (int i = 0; i < NUM_REGS; i++) begin
            exp_reg[i] = '0;
            image[i]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(nv_req == 1'b0, "R1 no request after reset", 32'(nv_req), 0);
        chk(dev_addr == 3'd0, "R1 address after reset", 32'(dev_addr), 0);
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_id = ID_W'(i);
            #1;
            chk(rd_data == '0, "R1 register after reset", 32'(rd_data), 0);
        end
        idle(10);
        chk(log_n == 0, "R1 quiet after reset", 32'(log_n), 0);

        // R3 automatic mode: ordinary write commits everything
        do_write(1, 16'h1234);
        idle(30);
        expect_full("R3 auto full commit");
        log_n = 0;

        // R2 reserved bits, R6 single commit in automatic mode, R9 address
        do_write(BUS, 16'hFFF5);
        idle(20);
        expect_single("R6 cfg write auto mode");
        rd_id = ID_W'(BUS);
        #1;
        chk(rd_data == 16'h0005, "R2 reserved bits read zero", 32'(rd_data), 32'h5);
        chk(dev_addr == 3'd5, "R9 address follows write", 32'(dev_addr), 5);
        log_n = 0;

        // switch to deferred mode (write-control bit 3 set)
        do_write(BUS, 16'h000D);
        idle(20);
        expect_single("R6 cfg write sets deferred mode");
        log_n = 0;

        // R4 deferred mode: ordinary writes stay in the shadow registers
        do_write(0, 16'hAAAA);
        do_write(2, 16'h5555);
        idle(30);
        chk(log_n == 0, "R4 no request in deferred mode", 32'(log_n), 0);
        rd_id = ID_W'(0);
        #1;
        chk(rd_data == 16'hAAAA, "R4 shadow updated", 32'(rd_data), 32'hAAAA);

        // R5 explicit commit
        do_cmd();
        idle(30);
        expect_full("R5 command full commit");
        for (int i = 0; i < NUM_REGS; i++)
            chk(image[i] == exp_reg[i], "R10 image after commit", 32'(image[i]), 32'(exp_reg[i]));
        log_n = 0;

        // R6 cfg write in deferred mode still commits at once
        do_write(BUS, 16'h800A);
        idle(20);
        expect_single("R6 cfg write deferred mode");
        chk(dev_addr == 3'd2, "R9 address in deferred mode", 32'(dev_addr), 2);
        log_n = 0;

        // R7/R8 long busy: commands during a running commit merge into one
        busy_fix = 8;
        do_cmd();
        idle(3);
        do_cmd();
        do_cmd();
        do_cmd();
        idle(200);
        chk(log_n == 2 * NUM_REGS, "R8 merged commands", 32'(log_n), 2 * NUM_REGS);
        for (int i = 0; i < 2 * NUM_REGS; i++)
            if (i < log_n) chk(log_id[i] == ID_W'(i % NUM_REGS), "R5 order after merge",
                               32'(log_id[i]), 32'(i % NUM_REGS));
        busy_fix = 0;
        log_n = 0;

        // random phase
        busy_max = 3;
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(9, 0));
            if (op < 5) do_write(int'($urandom_range(NUM_REGS - 1, 0)), DATA_W'($urandom));
            else if (op < 7) do_cmd();
            else idle(1);
        end
        do_cmd();
        idle(300);
        for (int i = 0; i < NUM_REGS; i++)
            chk(image[i] == exp_reg[i], "R10 image after random phase", 32'(image[i]), 32'(exp_reg[i]));
        chk(dev_addr == exp_reg[BUS][2:0], "R9 address after random phase",
            32'(dev_addr), 32'(exp_reg[BUS][2:0]));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule